// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Conditioner

This block sits next to a small processor and derives its timing support from one fast source clock. It produces a processor clock level at one third of the source rate (high for one source cycle out of three), a peripheral clock level at one sixth of the source rate with equal high and low times, and an oscillator enable that follows the source clock once the block is running. All outputs are registered on the source clock, so downstream logic can treat them as clean levels or as enables.

The block also conditions two slow control inputs. An active-low external reset request is passed through a short shift chain that advances only on falling edges of the processor clock. The result is an active-high reset that is aligned to that edge. Two ready inputs from slow devices are each qualified by their own active-low address enable, merged, and passed through a synchronizer that advances on rising edges of the processor clock. A select pin chooses whether the merged ready is taken after one stage or after two. The processor-side ready is held low while the conditioned reset is high.

A separate asynchronous power-on reset puts the divider into a fixed phase, so the first processor clock high phase begins on the first source edge after that reset is released.

Top module: `clk_reset_ready_gen`

## Requirements
- R1: `proc_clk` is high in exactly one source cycle out of every three. After `pwr_rst_n` is released, it is high after source edges 1, 4, 7, … and low after all other edges.
- R2: `periph_clk` starts low and toggles only when `proc_clk` rises. Its first high phase therefore begins at source edge 1, and it has a period of six source cycles with three high and three low.
- R3: `osc_en` is low while `pwr_rst_n` is low. It is high after every source edge that follows the release.
- R4: `reset_out` is high during power-on reset, and it stays high while `res_n` is held low.
- R5: `reset_out` changes only on source edges where `proc_clk` falls (edges 2, 5, 8, …). It follows the inverse of `res_n` after two such falling edges: the first samples `res_n`, and the second moves the result to the output.
- R6: A ready input contributes only while its paired address enable is low (`aen_a_n` for `rdy_a`, `aen_b_n` for `rdy_b`). A ready input is ignored while its enable is high.
- R7: The two qualified ready inputs are combined by logical OR.
- R8: With `one_stage_sel` = 1, `ready` shows the qualified value sampled at the latest `proc_clk` rising edge. With `one_stage_sel` = 0, `ready` shows the value sampled at the rising edge before that one.
- R9: `ready` is low whenever `reset_out` is high.
- R10: The ready synchronizer stages load new values only on source edges where `proc_clk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast source clock |
| pwr_rst_n | input | 1 | Asynchronous power-on reset, active low, sets the divider phase |
| res_n | input | 1 | External reset request, active low |
| rdy_a | input | 1 | Ready from device group A |
| aen_a_n | input | 1 | Address enable for `rdy_a`, active low |
| rdy_b | input | 1 | Ready from device group B |
| aen_b_n | input | 1 | Address enable for `rdy_b`, active low |
| one_stage_sel | input | 1 | 1: one synchronizer stage, 0: two stages |
| proc_clk | output | 1 | Processor clock level, source/3, high one third |
| periph_clk | output | 1 | Peripheral clock level, source/6, 50% duty |
| osc_en | output | 1 | Source-rate enable, high once running |
| reset_out | output | 1 | Conditioned reset, active high |
| ready | output | 1 | Synchronized, qualified ready |

## Verification
A wrong divider phase shows up at `proc_clk` within three source cycles of the power-on release, and at `periph_clk` within six. A wrong reset chain length, or a wrong edge choice, shows up as `reset_out` moving one processor period early or late, or on an edge where `proc_clk` rises. A wrong ready stage count, gating or merge is exposed at the next processor rising edge after the stimulus, once the bench flips `one_stage_sel` and the address enables independently of the ready levels.

// File: rtl/clkcond_pkg.sv
package clkcond_pkg;

   // single-cycle markers for edges of the derived processor clock
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ticks_t;

endpackage

// File: rtl/clkcond_divider.sv
module clkcond_divider
   import clkcond_pkg::*;
#(
   parameter int DIV  = 3,
   parameter int HIGH = 1
) (
   input  logic        clk,
   input  logic        arst_n,
   output logic        proc_clk,
   output logic        periph_clk,
   output logic        osc_en,
   output edge_ticks_t ticks
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
   localparam logic [CW-1:0] HI_END = CW'(HIGH - 1);
   localparam logic [CW-1:0] HI_LIM = CW'(HIGH);

   generate
      if (DIV < 2 || HIGH < 1 || HIGH >= DIV) begin : g_bad_cfg
         $error("clkcond_divider: HIGH must lie in 1..DIV-1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt    = (cnt == LAST) ? '0 : cnt + 1'b1;
      ticks.rise = (cnt == LAST);
      ticks.fall = (cnt == HI_END);
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt        <= LAST;
         proc_clk   <= 1'b0;
         periph_clk <= 1'b0;
         osc_en     <= 1'b0;
      end else begin
         cnt      <= cnt_nxt;
         proc_clk <= (cnt_nxt < HI_LIM);
         osc_en   <= 1'b1;
         if (ticks.rise) periph_clk <= ~periph_clk;
      end
   end

   // R1: the phase marked as a rise leads to a high processor clock
   p_rise_high_r1: assert property (@(posedge clk) disable iff (!arst_n)
      ticks.rise |=> proc_clk);
   // R1: the phase marked as a fall leads to a low processor clock
   p_fall_low_r1: assert property (@(posedge clk) disable iff (!arst_n)
      ticks.fall |=> !proc_clk);
   // R2: peripheral clock moves only together with a processor clock rise
   p_periph_on_rise_r2: assert property (@(posedge clk) disable iff (!arst_n)
      !$stable(periph_clk) |-> $rose(proc_clk));
   // R3: enable never drops once running
   p_osc_hold_r3: assert property (@(posedge clk) disable iff (!arst_n)
      osc_en |=> osc_en);
endmodule

// File: rtl/clkcond_rst_sync.sv
module clkcond_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic fall_tick,
   input  logic ext_rst_n,
   output logic rst_out
);
   generate
      if (STAGES < 1 || STAGES > 8) begin : g_bad_cfg
         $error("clkcond_rst_sync: STAGES must lie in 1..8");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic d;
         if (i == 0) begin : g_head
            assign d = ~ext_rst_n;
         end else begin : g_link
            assign d = chain[i-1];
         end
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)        chain[i] <= 1'b1;
            else if (fall_tick) chain[i] <= d;
         end
      end
   endgenerate

   assign rst_out = chain[STAGES-1];

   // R5: output moves only after an edge marked as a processor clock fall
   p_rst_on_fall_r5: assert property (@(posedge clk) disable iff (!arst_n)
      !$stable(rst_out) |-> $past(fall_tick));
   // R4: a held request keeps the chain head asserted after the next fall
   p_rst_head_r4: assert property (@(posedge clk) disable iff (!arst_n)
      (fall_tick && !ext_rst_n) |=> chain[0]);
endmodule

// File: rtl/clkcond_rdy_sync.sv
module clkcond_rdy_sync #(
   parameter int SHORT = 1,
   parameter int LONG  = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rise_tick,
   input  logic rdy_a,
   input  logic aen_a_n,
   input  logic rdy_b,
   input  logic aen_b_n,
   input  logic one_stage,
   input  logic hold_off,
   output logic ready
);
   generate
      if (SHORT < 1 || LONG <= SHORT || LONG > 8) begin : g_bad_cfg
         $error("clkcond_rdy_sync: need 1 <= SHORT < LONG <= 8");
      end
   endgenerate

   logic            merged;
   logic [LONG-1:0] stg;

   assign merged = (rdy_a & ~aen_a_n) | (rdy_b & ~aen_b_n);

   generate
      for (genvar i = 0; i < LONG; i++) begin : g_stage
         logic d;
         if (i == 0) begin : g_head
            assign d = merged;
         end else begin : g_link
            assign d = stg[i-1];
         end
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)        stg[i] <= 1'b0;
            else if (rise_tick) stg[i] <= d;
         end
      end
   endgenerate

   assign ready = (one_stage ? stg[SHORT-1] : stg[LONG-1]) & ~hold_off;

   // R10: first stage loads only after an edge marked as a processor clock rise
   p_stage_on_rise_r10: assert property (@(posedge clk) disable iff (!arst_n)
      !$stable(stg[0]) |-> $past(rise_tick));
   // R6: with both enables inactive a rise loads a zero
   p_gate_off_r6: assert property (@(posedge clk) disable iff (!arst_n)
      (rise_tick && aen_a_n && aen_b_n) |=> !stg[0]);
   // R7: either qualified input alone loads a one
   p_merge_or_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (rise_tick && ((rdy_a && !aen_a_n) || (rdy_b && !aen_b_n))) |=> stg[0]);
endmodule

// File: rtl/clk_reset_ready_gen.sv
module clk_reset_ready_gen
   import clkcond_pkg::*;
#(
   parameter int DIV        = 3,
   parameter int HIGH       = 1,
   parameter int RST_STAGES = 2,
   parameter int RDY_SHORT  = 1,
   parameter int RDY_LONG   = 2
) (
   input  logic osc_clk,
   input  logic pwr_rst_n,
   input  logic res_n,
   input  logic rdy_a,
   input  logic aen_a_n,
   input  logic rdy_b,
   input  logic aen_b_n,
   input  logic one_stage_sel,
   output logic proc_clk,
   output logic periph_clk,
   output logic osc_en,
   output logic reset_out,
   output logic ready
);
   edge_ticks_t ticks;

   clkcond_divider #(.DIV(DIV), .HIGH(HIGH)) u_div (
      .clk        (osc_clk),
      .arst_n     (pwr_rst_n),
      .proc_clk   (proc_clk),
      .periph_clk (periph_clk),
      .osc_en     (osc_en),
      .ticks      (ticks)
   );

   clkcond_rst_sync #(.STAGES(RST_STAGES)) u_rst (
      .clk       (osc_clk),
      .arst_n    (pwr_rst_n),
      .fall_tick (ticks.fall),
      .ext_rst_n (res_n),
      .rst_out   (reset_out)
   );

   clkcond_rdy_sync #(.SHORT(RDY_SHORT), .LONG(RDY_LONG)) u_rdy (
      .clk       (osc_clk),
      .arst_n    (pwr_rst_n),
      .rise_tick (ticks.rise),
      .rdy_a     (rdy_a),
      .aen_a_n   (aen_a_n),
      .rdy_b     (rdy_b),
      .aen_b_n   (aen_b_n),
      .one_stage (one_stage_sel),
      .hold_off  (reset_out),
      .ready     (ready)
   );

   // R5: conditioned reset moves only together with a processor clock fall
   p_rst_with_fall_r5: assert property (@(posedge osc_clk) disable iff (!pwr_rst_n)
      !$stable(reset_out) |-> $fell(proc_clk));
   // R1: a processor clock high phase lasts a single source cycle
   p_proc_short_high_r1: assert property (@(posedge osc_clk) disable iff (!pwr_rst_n)
      (HIGH == 1 && proc_clk) |=> !proc_clk);
endmodule

// File: tb/clk_reset_ready_gen_bench.sv
module clk_reset_ready_gen_bench;
   logic osc_clk = 1'b0;
   logic pwr_rst_n, res_n, rdy_a, aen_a_n, rdy_b, aen_b_n, one_stage_sel;
   logic proc_clk, periph_clk, osc_en, reset_out, ready;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // reference state, advanced from the requirement rules
   int   k = 0;
   logic m_proc, m_periph, m_osc, m_r1, m_r2, m_s1, m_s2;
   string rdy_tag;

   always #2.5 osc_clk = ~osc_clk;

   clk_reset_ready_gen u_clk_reset_ready_gen (
      .osc_clk, .pwr_rst_n, .res_n, .rdy_a, .aen_a_n, .rdy_b, .aen_b_n,
      .one_stage_sel, .proc_clk, .periph_clk, .osc_en, .reset_out, .ready
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("[TB] FAIL %s at edge %0d: got %b expected %b", req, k, act, exp);
      end
   endtask

   function automatic logic qualified();
      return (rdy_a & ~aen_a_n) | (rdy_b & ~aen_b_n);
   endfunction

   // advance reference for source edge k with the inputs held across it
   task automatic model_step();
      logic g;
      g = qualified();
      k++;
      if (k % 3 == 2) begin            // R5: processor clock falls here
         m_r2 = m_r1;
         m_r1 = ~res_n;
      end
      if (k % 3 == 1) begin            // R10, R2: processor clock rises here
         m_s2 = m_s1;
         m_s1 = g;
         m_periph = ~m_periph;
      end
      m_proc = (k % 3 == 1);
      m_osc  = 1'b1;
   endtask

   task automatic check_all();
      logic exp_rdy;
      exp_rdy = (one_stage_sel ? m_s1 : m_s2) & ~m_r2;
      check("R1", proc_clk, m_proc);
      check("R2", periph_clk, m_periph);
      check("R3", osc_en, m_osc);
      check(res_n ? "R5" : "R4", reset_out, m_r2);
      check(m_r2 ? "R9" : rdy_tag, ready, exp_rdy);
   endtask

   task automatic cycle();
      @(negedge osc_clk);
      model_step();
      check_all();
   endtask

   initial begin
      #1ms;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("[TB] FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      pwr_rst_n = 1'b0; res_n = 1'b0;
      rdy_a = 1'b1; aen_a_n = 1'b0; rdy_b = 1'b0; aen_b_n = 1'b1;
      one_stage_sel = 1'b1;
      rdy_tag = "R8";
      // reset state, R1..R4, R9
      repeat (3) begin
         @(negedge osc_clk);
         check("R1", proc_clk, 1'b0);
         check("R2", periph_clk, 1'b0);
         check("R3", osc_en, 1'b0);
         check("R4", reset_out, 1'b1);
         check("R9", ready, 1'b0);
      end
      m_proc = 0; m_periph = 0; m_osc = 0;
      m_r1 = 1; m_r2 = 1; m_s1 = 0; m_s2 = 0;
      pwr_rst_n = 1'b1;
      // R4/R9: request held low, qualified ready high
      repeat (12) cycle();
      // R6: ready present but enable inactive
      res_n = 1'b1;
      aen_a_n = 1'b1; rdy_tag = "R6";
      repeat (12) cycle();
      // R7: only group B qualified
      rdy_a = 1'b0; rdy_b = 1'b1; aen_b_n = 1'b0; rdy_tag = "R7";
      repeat (6) cycle();
      // R8: two-stage depth, drop ready and watch latency
      one_stage_sel = 1'b0; rdy_tag = "R8";
      rdy_b = 1'b0;
      repeat (9) cycle();
      rdy_a = 1'b1; aen_a_n = 1'b0;
      repeat (9) cycle();
      // random mix
      rdy_tag = "R6/R7/R8";
      for (int i = 0; i < 3000; i++) begin
         rdy_a   = $urandom_range(0, 1);
         rdy_b   = $urandom_range(0, 1);
         aen_a_n = $urandom_range(0, 1);
         aen_b_n = $urandom_range(0, 1);
         if ($urandom_range(0, 7) == 0) one_stage_sel = ~one_stage_sel;
         if ($urandom_range(0, 59) == 0) res_n = ~res_n;
         cycle();
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule